// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a per-core write buffer. It sits between one core's load/store port and a shared memory port. Stores from the core go into a small FIFO of address/value pairs and return at once. The queue then writes them to memory in the order they arrived, one per cycle. Loads look in the queue first. If one or more queued stores target the load address, the value of the youngest of them is returned and memory is not touched. If no queued store matches, the load reads memory.

An external lock arbiter drives `blocked` while another core holds the global lock. While it is high, the queue does not drain and memory reads are suppressed. Loads that hit in the queue still complete. Stores are still accepted while there is space. A full fence completes only once the queue is empty. The load-only and store-only fence kinds complete at once and leave the queue unchanged. The `q_empty` output lets the arbiter see when this core has nothing pending.

The load path, the fence path and the memory read path are all combinational. A load is served in the cycle it is presented, as long as `ld_ready` is high. The queue depth must be a power of two, at least 2.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1, `st_ready`=1 and `mem_wr_en`=0. No memory write is issued until a store has been accepted.
- R2: A store is accepted on a clock edge with `st_valid` and `st_ready` high, whatever the state of `blocked`. `st_ready` is low exactly when DEPTH entries are queued, and a store presented then is dropped.
- R3: While the queue is non-empty and `blocked` is low, `mem_wr_en` is high and carries the oldest entry's address and data. That entry is removed at the next edge, so entries reach memory in arrival order, one per cycle.
- R4: While `blocked` is high, `mem_wr_en` stays low and the queue keeps its contents.
- R5: A load whose address matches one or more queued entries returns the data of the most recently accepted matching entry in the same cycle, with `ld_ready`=1.
- R6: A load that matches no queued entry drives `mem_rd_en`=1 and returns `mem_rd_data` when `blocked` is low. When `blocked` is high, it sees `ld_ready`=0 and `mem_rd_en`=0.
- R7: A load that matches a queued entry never raises `mem_rd_en`. This holds even while that entry is being written to memory.
- R8: With `fence_kind`=2'b10 or 2'b11 (full fence), `fence_done` is high only while the queue is empty.
- R9: With `fence_kind`=2'b00 (load fence) or 2'b01 (store fence), `fence_done` equals `fence_req`. These fences do not change the queue's contents, its occupancy or the memory writes.
- R10: `q_empty` is high exactly when no entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Queue has space |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | AW | Load address |
| ld_ready | output | 1 | Load served this cycle |
| ld_rdata | output | DW | Load data |
| fence_req | input | 1 | Fence request |
| fence_kind | input | 2 | 00 load, 01 store, 1x full |
| fence_done | output | 1 | Fence may complete |
| blocked | input | 1 | Another core holds the global lock |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, same cycle |
| q_empty | output | 1 | No entries queued |

## Verification
The assertions take for granted that the core presents a store and a load in separate cycles. A load in the same cycle as a store is not ordered against that store, because the store enters the queue only at the edge. They also assume that `mem_rd_data` is valid in the cycle `mem_rd_en` is high. The bench keeps to both. It changes `st_valid` and `ld_valid` only on falling edges and never raises both together. It serves reads combinationally from its own memory array, which it updates on each write strobe. `blocked` is treated as arbitrary, and the bench toggles it in the middle of a drain.

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_ready,
  output logic [DW-1:0] ld_rdata,
  input  logic          fence_req,
  input  logic [1:0]    fence_kind,
  output logic          fence_done,
  input  logic          blocked,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          q_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          push, pop, hit;
  logic [DW-1:0] hit_data;

  assign q_empty    = (count == '0);
  assign st_ready   = (count != CW'(DEPTH));
  assign push       = st_valid && st_ready;
  assign pop        = !q_empty && !blocked;

  assign mem_wr_en   = pop;
  assign mem_wr_addr = addr_q[head];
  assign mem_wr_data = data_q[head];

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(i);
      if (CW'(i) < count && addr_q[idx] == ld_addr) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
  end

  assign mem_rd_en   = ld_valid && !hit && !blocked;
  assign mem_rd_addr = ld_addr;
  assign ld_ready    = hit || !blocked;
  assign ld_rdata    = hit ? hit_data : mem_rd_data;

  assign fence_done  = fence_req && (!fence_kind[1] || q_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
    end
  end
endmodule

// File: rtl/store_fwd_buf_chk.sv
module store_fwd_buf_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          blocked,
  input logic          mem_wr_en,
  input logic          mem_rd_en,
  input logic          fence_req,
  input logic [1:0]    fence_kind,
  input logic          fence_done,
  input logic          q_empty,
  input logic [CW-1:0] count
);
  logic seen_store;
  always_ff @(posedge clk)
    if (!rst_n) seen_store <= 1'b0;
    else if (st_valid && st_ready) seen_store <= 1'b1;

  // R1
  first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_store |-> !mem_wr_en);
  // R2
  full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !st_ready);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !mem_wr_en) |=> count == $past(count) + 1'b1);
  // R4
  blk_no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !mem_wr_en);
  // R4
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !st_valid) |=> $stable(count));
  // R6
  blk_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !mem_rd_en);
  // R8
  fence_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && fence_kind[1]) |-> q_empty);
  // R9
  light_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req && !fence_kind[1]) |-> fence_done);
  // R10
  empty_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !mem_wr_en);
endmodule

bind store_fwd_buf store_fwd_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .blocked(blocked), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
  .fence_req(fence_req), .fence_kind(fence_kind), .fence_done(fence_done),
  .q_empty(q_empty), .count(count)
);

// File: tb/sim_store_fwd_buf.sv
module sim_store_fwd_buf;
  localparam int AW = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, ld_valid = 0, fence_req = 0, blocked = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [1:0] fence_kind = 2'b00;
  logic st_ready, ld_ready, fence_done, mem_wr_en, mem_rd_en, q_empty;
  logic [DW-1:0] ld_rdata, mem_wr_data, mem_rd_data;
  logic [AW-1:0] mem_wr_addr, mem_rd_addr;
  logic [DW-1:0] mem [256];
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  store_fwd_buf u0 (.*);

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + DW'(i);
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  assign mem_rd_data = mem[mem_rd_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 empty", q_empty, 1);
    chk("R1 ready", st_ready, 1);
    repeat (3) begin
      chk("R1 no write", mem_wr_en, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_fill_blocked;
    blocked = 1;
    push(8'd3, 16'h0A0A); chk("R4 no drain", mem_wr_en, 0);
    push(8'd5, 16'h0505);
    push(8'd3, 16'h0B0B);
    push(8'd7, 16'h0707);
    #1;
    chk("R2 full", st_ready, 0);
    chk("R10 not empty", q_empty, 0);
    chk("R4 no drain", mem_wr_en, 0);
    push(8'd9, 16'h0999);
  endtask

  task automatic t_load_blocked;
    ld_valid = 1; ld_addr = 8'd3; #1;
    chk("R5 youngest", ld_rdata, 16'h0B0B);
    chk("R5 ready", ld_ready, 1);
    chk("R7 no read", mem_rd_en, 0);
    ld_addr = 8'd5; #1;
    chk("R5 single", ld_rdata, 16'h0505);
    ld_addr = 8'd9; #1;
    chk("R6 stall", ld_ready, 0);
    chk("R6 no read", mem_rd_en, 0);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic t_fences_blocked;
    fence_req = 1; fence_kind = 2'b10; #1;
    chk("R8 full pending", fence_done, 0);
    fence_kind = 2'b11; #1;
    chk("R8 full pending 11", fence_done, 0);
    fence_kind = 2'b00; #1;
    chk("R9 load fence", fence_done, 1);
    fence_kind = 2'b01; #1;
    chk("R9 store fence", fence_done, 1);
    @(negedge clk);
    fence_req = 0; #1;
    chk("R9 queue kept", st_ready, 0);
    chk("R9 not empty", q_empty, 0);
    chk("R9 no write", mem_wr_en, 0);
  endtask

  task automatic drain_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
    #1;
    chk("R3 write", mem_wr_en, 1);
    chk("R3 addr", mem_wr_addr, a);
    chk("R3 data", mem_wr_data, d);
    @(negedge clk);
  endtask

  task automatic t_drain;
    blocked = 0;
    drain_one(8'd3, 16'h0A0A);
    drain_one(8'd5, 16'h0505);
    blocked = 1; #1;
    chk("R4 pause", mem_wr_en, 0);
    @(negedge clk);
    blocked = 0;
    drain_one(8'd3, 16'h0B0B);
    drain_one(8'd7, 16'h0707);
    fence_req = 1; fence_kind = 2'b10; #1;
    chk("R10 empty", q_empty, 1);
    chk("R2 dropped store", mem_wr_en, 0);
    chk("R8 full done", fence_done, 1);
    @(negedge clk);
    fence_req = 0;
  endtask

  task automatic t_load_mem;
    ld_valid = 1; ld_addr = 8'd3; #1;
    chk("R6 read", mem_rd_en, 1);
    chk("R6 data", ld_rdata, 16'h0B0B);
    ld_addr = 8'd9; #1;
    chk("R6 untouched", ld_rdata, 16'h1009);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic t_fwd_draining;
    push(8'd10, 16'hAAAA);
    ld_valid = 1; ld_addr = 8'd10; #1;
    chk("R7 draining", mem_wr_en, 1);
    chk("R7 fwd data", ld_rdata, 16'hAAAA);
    chk("R7 no read", mem_rd_en, 0);
    @(negedge clk); #1;
    chk("R6 after drain", ld_rdata, 16'hAAAA);
    chk("R6 read used", mem_rd_en, 1);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fill_blocked;
    t_load_blocked;
    t_fences_blocked;
    t_drain;
    t_load_mem;
    t_fwd_draining;
    finish_run;
  end

  initial begin
    #160000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule